// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves the jump instructions of a 64-bit virtual-machine instruction set. Each cycle it takes the current program counter (counted in instructions), the 4-bit jump code, a source-select bit, a class bit, the two operands, the 16-bit offset field and the 32-bit immediate field. It reports whether the jump is taken and gives the program counter of the next instruction.

A conditional jump compares the destination operand with either the source operand or the sign-extended immediate. The comparison is one of equality, bit test, unsigned or signed ordering. The class bit picks the compare width: the full 64 bits, or only the low 32 bits. The displacement is the sign-extended offset field, with one exception. The unconditional jump in the 32-bit class uses the immediate field instead, which gives it a long reach. The displacement is added to PC+1. A jump that is not taken goes to PC+1.

The result is captured in an output register on every clock edge, so each set of inputs shows at the outputs one cycle later. There is no handshake, and a new instruction can be presented every cycle.

Top module: `bvm_branch_unit`

## Requirements
- R1: While `rst_n` is low, `taken_o` is 0 and `next_pc_o` is 0. Out of reset, the outputs show the result for the inputs sampled at the previous rising clock edge.
- R2: Jump code 0 is always taken. It ignores the operands and the source-select bit. With `jmp32_i`=0 the target is PC+1 plus the sign-extended `off_i`. With `jmp32_i`=1 the target is PC+1 plus the sign-extended `imm_i`.
- R3: Every conditional code takes its displacement from `off_i`, sign-extended, in both classes. When taken, the target is PC+1+offset.
- R4: When a jump is not taken, `next_pc_o` is PC+1. All target arithmetic wraps modulo 2^PC_W.
- R5: Code 1 jumps when dst == operand. Code 5 jumps when dst != operand. Code 4 jumps when (dst & operand) is nonzero.
- R6: Unsigned codes: code 2 jumps on dst > operand, code 3 on dst >= operand, code 10 on dst < operand and code 11 on dst <= operand.
- R7: Signed (two's-complement) codes: code 6 jumps on dst > operand, code 7 on dst >= operand, code 12 on dst < operand and code 13 on dst <= operand.
- R8: With `jmp32_i`=1 only bits 31:0 of both sides are compared, and bit 31 is the sign bit. With `jmp32_i`=0 all 64 bits are compared, and bit 63 is the sign bit.
- R9: With `src_reg_i`=1 the compared operand is `src_i`. With `src_reg_i`=0 it is `imm_i` sign-extended to 64 bits.
- R10: Codes 8, 9, 14 and 15 are never taken, and for them `next_pc_o` is PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current program counter, in instructions |
| jcode_i | input | 4 | Jump condition code |
| src_reg_i | input | 1 | 1: compare against `src_i`; 0: compare against `imm_i` |
| jmp32_i | input | 1 | 1: 32-bit jump class; 0: 64-bit jump class |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand |
| off_i | input | 16 | Signed offset field |
| imm_i | input | 32 | Signed immediate field |
| taken_o | output | 1 | Jump taken (registered) |
| next_pc_o | output | 32 | Next program counter (registered) |

## Verification
Random operand pairs are drawn in four patterns: fully random, identical, identical in the low half only, and small values near zero. Identical pairs separate the strict orderings from the inclusive ones. Pairs that differ only in the upper half show whether the 32-bit class really masks the high bits. Directed cases place the sign bit so that signed and unsigned orderings disagree, and some of them set it at bit 31 but not bit 63 so that the two classes also disagree. Further directed cases compare an all-ones immediate against an all-ones destination, which shows that the immediate is sign-extended, and run program counters near zero and near the maximum to exercise wraparound with negative offsets.

// File: rtl/bvm_br_pkg.sv
package bvm_br_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_ANY    = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_RSV8   = 4'h8,
        JC_RSV9   = 4'h9,
        JC_ULT    = 4'hA,
        JC_ULE    = 4'hB,
        JC_SLT    = 4'hC,
        JC_SLE    = 4'hD,
        JC_RSVE   = 4'hE,
        JC_RSVF   = 4'hF
    } jcode_e;

    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic any;
    } cmp_flags_t;

endpackage

// File: rtl/bvm_cmp_flags.sv
module bvm_cmp_flags
    import bvm_br_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cmp_flags_t   flags_o
);
    always_comb begin
        flags_o.eq  = (a_i == b_i);
        flags_o.ult = (a_i < b_i);
        flags_o.slt = ($signed(a_i) < $signed(b_i));
        flags_o.any = |(a_i & b_i);
    end
endmodule

// File: rtl/bvm_cond_decode.sv
module bvm_cond_decode
    import bvm_br_pkg::*;
(
    input  logic [3:0]  jcode_i,
    input  cmp_flags_t  flags_i,
    output logic        take_o,
    output logic        uncond_o
);
    jcode_e code;
    assign code = jcode_e'(jcode_i);

    always_comb begin
        uncond_o = 1'b0;
        unique case (code)
            JC_ALWAYS: begin take_o = 1'b1; uncond_o = 1'b1; end
            JC_EQ:     take_o = flags_i.eq;
            JC_NE:     take_o = !flags_i.eq;
            JC_ANY:    take_o = flags_i.any;
            JC_UGT:    take_o = !flags_i.ult && !flags_i.eq;
            JC_UGE:    take_o = !flags_i.ult;
            JC_ULT:    take_o = flags_i.ult;
            JC_ULE:    take_o = flags_i.ult || flags_i.eq;
            JC_SGT:    take_o = !flags_i.slt && !flags_i.eq;
            JC_SGE:    take_o = !flags_i.slt;
            JC_SLT:    take_o = flags_i.slt;
            JC_SLE:    take_o = flags_i.slt || flags_i.eq;
            JC_RSV8, JC_RSV9, JC_RSVE, JC_RSVF: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bvm_target_calc.sv
module bvm_target_calc #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic             use_imm_i,
    input  logic             take_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [PC_W-1:0]  next_pc_o
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp;

    assign seq_pc = pc_i + PC_W'(1);

    always_comb begin
        if (use_imm_i) disp = PC_W'($signed(imm_i));
        else           disp = PC_W'($signed(off_i));
        next_pc_o = take_i ? (seq_pc + disp) : seq_pc;
    end
endmodule

// File: rtl/bvm_branch_unit.sv
module bvm_branch_unit
    import bvm_br_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int OFF_W    = 16,
    parameter int IMM_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [3:0]        jcode_i,
    input  logic              src_reg_i,
    input  logic              jmp32_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o
);
    localparam int NUM_W = 2;

    logic [DATA_W-1:0] operand;
    cmp_flags_t        flags [NUM_W];
    cmp_flags_t        flags_sel;
    logic              take_d;
    logic              uncond;
    logic [PC_W-1:0]   next_pc_d;

    assign operand = src_reg_i ? src_i : DATA_W'($signed(imm_i));

    for (genvar gi = 0; gi < NUM_W; gi++) begin : g_width
        localparam int W = (gi == 0) ? DATA_W : NARROW_W;
        bvm_cmp_flags #(.W(W)) u_cmp (
            .a_i     (dst_i[W-1:0]),
            .b_i     (operand[W-1:0]),
            .flags_o (flags[gi])
        );
    end

    assign flags_sel = jmp32_i ? flags[1] : flags[0];

    bvm_cond_decode u_dec (
        .jcode_i  (jcode_i),
        .flags_i  (flags_sel),
        .take_o   (take_d),
        .uncond_o (uncond)
    );

    bvm_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
        .pc_i      (pc_i),
        .use_imm_i (uncond && jmp32_i),
        .take_i    (take_d),
        .off_i     (off_i),
        .imm_i     (imm_i),
        .next_pc_o (next_pc_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else begin
            taken_o   <= take_d;
            next_pc_o <= next_pc_d;
        end
    end
endmodule

// File: rtl/bvm_branch_unit_chk.sv
module bvm_branch_unit_chk #(
    parameter int PC_W   = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc_i,
    input logic [3:0]        jcode_i,
    input logic              src_reg_i,
    input logic              jmp32_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [OFF_W-1:0]  off_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              taken_o,
    input logic [PC_W-1:0]   next_pc_o
);
    logic primed;

    always_ff @(posedge clk) primed <= rst_n;

    p_always_jump_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(jcode_i) == 4'd0) |-> taken_o);

    p_long_jump_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(jcode_i) == 4'd0 && $past(jmp32_i)) |->
        (next_pc_o == $past(pc_i) + PC_W'(1) + PC_W'($signed($past(imm_i)))));

    p_cond_offset_r3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (taken_o && $past(jcode_i) != 4'd0) |->
        (next_pc_o == $past(pc_i) + PC_W'(1) + PC_W'($signed($past(off_i)))));

    p_seq_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        !taken_o |-> (next_pc_o == $past(pc_i) + PC_W'(1)));

    p_equal_taken_r5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(jcode_i) == 4'd1 && $past(src_reg_i) && $past(dst_i) == $past(src_i))
        |-> taken_o);

    p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ($past(jcode_i) == 4'd8 || $past(jcode_i) == 4'd9 ||
         $past(jcode_i) == 4'd14 || $past(jcode_i) == 4'd15) |-> !taken_o);
endmodule

bind bvm_branch_unit bvm_branch_unit_chk #(
    .PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IMM_W(IMM_W)
) u_chk (.*);

// File: tb/bvm_branch_unit_test.sv
module bvm_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [3:0]  jcode_i = '0;
    logic        src_reg_i = 1'b0;
    logic        jmp32_i = 1'b0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [15:0] off_i = '0;
    logic [31:0] imm_i = '0;
    logic        taken_o;
    logic [31:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bvm_branch_unit uut (.*);

    function automatic logic model_take(logic [3:0] c, logic sr, logic j32,
                                        logic [63:0] d, logic [63:0] s, logic [31:0] im);
        logic [63:0] b, ua, ub;
        logic signed [63:0] sa, sb;
        b = sr ? s : {{32{im[31]}}, im};
        if (j32) begin
            ua = {32'b0, d[31:0]};          ub = {32'b0, b[31:0]};
            sa = {{32{d[31]}}, d[31:0]};    sb = {{32{b[31]}}, b[31:0]};
        end else begin
            ua = d; ub = b; sa = d; sb = b;
        end
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return ua == ub;
            4'd5:  return ua != ub;
            4'd4:  return (ua & ub) != 0;
            4'd2:  return ua > ub;
            4'd3:  return ua >= ub;
            4'd10: return ua < ub;
            4'd11: return ua <= ub;
            4'd6:  return sa > sb;
            4'd7:  return sa >= sb;
            4'd12: return sa < sb;
            4'd13: return sa <= sb;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_pc(logic tk, logic [3:0] c, logic j32,
                                             logic [31:0] pc, logic [15:0] of, logic [31:0] im);
        logic [31:0] disp;
        disp = (c == 4'd0 && j32) ? im : {{16{of[15]}}, of};
        return tk ? pc + 32'd1 + disp : pc + 32'd1;
    endfunction

    function automatic string tag_for(logic [3:0] c);
        case (c)
            4'd0: return "R2";
            4'd1, 4'd4, 4'd5: return "R5";
            4'd2, 4'd3, 4'd10, 4'd11: return "R6";
            4'd6, 4'd7, 4'd12, 4'd13: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(string tag, logic [31:0] pc, logic [3:0] c, logic sr, logic j32,
                         logic [63:0] d, logic [63:0] s, logic [15:0] of, logic [31:0] im);
        logic tk;
        pc_i = pc; jcode_i = c; src_reg_i = sr; jmp32_i = j32;
        dst_i = d; src_i = s; off_i = of; imm_i = im;
        tk = model_take(c, sr, j32, d, s, im);
        @(negedge clk);
        check(tag, "taken", {63'b0, taken_o}, {63'b0, tk});
        check(tag, "next_pc", {32'b0, next_pc_o}, {32'b0, model_pc(tk, c, j32, pc, of, im)});
    endtask

    task automatic expect_pair(string tag, logic exp_tk, logic [31:0] exp_pc);
        check(tag, "taken", {63'b0, taken_o}, {63'b0, exp_tk});
        check(tag, "next_pc", {32'b0, next_pc_o}, {32'b0, exp_pc});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds outputs clear even with an always-taken jump presented
        pc_i = 32'h1234; jcode_i = 4'd0; off_i = 16'd9;
        repeat (3) @(negedge clk);
        expect_pair("R1", 1'b0, 32'h0);
        rst_n = 1'b1;

        // R2: unconditional, both classes, both source bits, operands irrelevant
        apply("R2", 32'd100, 4'd0, 1'b0, 1'b0, 64'd1, 64'd2, 16'hFFFD, 32'd1000);
        expect_pair("R2", 1'b1, 32'd98);
        apply("R2", 32'd100, 4'd0, 1'b1, 1'b1, 64'd1, 64'd2, 16'd5, 32'h0010_0000);
        expect_pair("R2", 1'b1, 32'h0010_0065);
        apply("R2", 32'd100, 4'd0, 1'b0, 1'b1, '1, 64'd0, 16'd5, 32'hFFFF_FF00);
        // R3: conditional jump in 32-bit class still uses offset
        apply("R3", 32'd50, 4'd1, 1'b1, 1'b1, 64'd7, 64'd7, 16'd7, 32'd99);
        expect_pair("R3", 1'b1, 32'd58);
        // R4: not taken, wraps at the top
        apply("R4", 32'hFFFF_FFFF, 4'd2, 1'b1, 1'b0, 64'd1, 64'd2, 16'd40, 32'd0);
        expect_pair("R4", 1'b0, 32'h0);
        apply("R4", 32'h0, 4'd1, 1'b1, 1'b0, 64'd3, 64'd3, 16'hFFFF, 32'd0);
        expect_pair("R4", 1'b1, 32'h0);
        apply("R4", 32'hFFFF_FFFF, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 16'd0, 32'd0);
        expect_pair("R4", 1'b1, 32'h0);
        // R8: upper halves differ, low halves equal
        apply("R8", 32'd10, 4'd1, 1'b1, 1'b1, 64'h1_0000_0005, 64'h2_0000_0005, 16'd3, 32'd0);
        expect_pair("R8", 1'b1, 32'd14);
        apply("R8", 32'd10, 4'd1, 1'b1, 1'b0, 64'h1_0000_0005, 64'h2_0000_0005, 16'd3, 32'd0);
        expect_pair("R8", 1'b0, 32'd11);
        apply("R8", 32'd10, 4'd6, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 16'd3, 32'd0);
        expect_pair("R8", 1'b0, 32'd11);
        apply("R8", 32'd10, 4'd6, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'd1, 16'd3, 32'd0);
        expect_pair("R8", 1'b1, 32'd14);
        // R7 vs R6: sign bit 63 separates signed from unsigned
        apply("R7", 32'd0, 4'd12, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'd1, 16'd2, 32'd0);
        apply("R6", 32'd0, 4'd10, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'd1, 16'd2, 32'd0);
        // R9: immediate sign-extended; register source selected
        apply("R9", 32'd20, 4'd1, 1'b0, 1'b0, '1, 64'd0, 16'd4, 32'hFFFF_FFFF);
        expect_pair("R9", 1'b1, 32'd25);
        apply("R9", 32'd20, 4'd1, 1'b1, 1'b0, '1, 64'd0, 16'd4, 32'hFFFF_FFFF);
        expect_pair("R9", 1'b0, 32'd21);
        // R10: reserved codes with operands that would satisfy any compare
        for (int k = 0; k < 4; k++) begin
            logic [3:0] rc;
            rc = (k == 0) ? 4'd8 : (k == 1) ? 4'd9 : (k == 2) ? 4'd14 : 4'd15;
            apply("R10", 32'd77, rc, 1'b1, k[0], 64'd5, 64'd5, 16'd9, 32'd3);
            expect_pair("R10", 1'b0, 32'd78);
        end

        // constrained random
        for (int n = 0; n < 800; n++) begin
            logic [63:0] d, s;
            logic [3:0] c;
            int mode;
            d = {$urandom, $urandom};
            mode = $urandom % 4;
            case (mode)
                0: s = {$urandom, $urandom};
                1: s = d;
                2: s = {~d[63:32], d[31:0]};
                default: begin
                    d = {{56{d[7]}}, d[7:0]};
                    s = {{56{1'b0}}, 8'($urandom)} - 64'd128;
                end
            endcase
            c = 4'($urandom);
            apply(tag_for(c), $urandom, c, 1'($urandom), 1'($urandom), d, s,
                  16'($urandom), (mode == 1) ? d[31:0] : $urandom);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule